// File: doc/BRIEF.md
# Fuse Word Auto-Read Sequencer

This block fetches one 32-bit word from a one-time-programmable fuse macro in response to a single register write. Software first clears the manual-mode bit. It then writes a read command that carries a 10-bit word address. From that point the block runs one free counter and derives all five macro control lines from it: chip select, program enable, load, address valid and strobe. Each line has its own start/end window in a timing register.

When the strobe window closes, the block samples the macro's data output into a readable data register and sets a sticky completion flag. Software clears that flag by writing 1 to it. A second bank of five timing registers holds program-pulse windows. That bank is plain storage and does not affect reads.

The register port is a plain 32-bit single-cycle bus. Writes take effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high, and is zero otherwise. Nothing at the edge of the block is handshaked, so there is no back-pressure: a command that arrives while the block cannot take it is dropped, and the busy bit tells software so.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset the block is in the following state:
  - chip select (`fuse_cs_n`) is high and the other four control lines are low;
  - the status register (0x18) and the data register (0x20) read 0;
  - the control register (0x00) reads 1, meaning manual mode;
  - busy (bit 31 of 0x24) reads 0.
- R2: A write to 0x24 starts a read only when all of the following hold:
  - bit 0 of 0x00 is 0;
  - bits 0 and 1 of the written word are both 1;
  - the block is not busy.

  The word address is taken from bits 25:16 of the written word and appears on `fuse_addr`. A command written while bit 0 of 0x00 is 1 starts nothing.
- R3: Take the edge that accepts the command as edge 0. A line whose window is start S and end E is asserted at the pins after edges S+1 through E, and deasserted after every other edge. A window with S equal to E never asserts its line.
- R4: Chip select is active low: `fuse_cs_n` is low only inside its window and high at all other times.
- R5: On the edge where the strobe pin falls (edge Estrobe+1), the data register loads `fuse_q` and bit 0 of status (0x18) becomes 1.
- R6: Busy (bit 31 of 0x24) reads 1 after edges 0 through M, where M is the largest of the five read-window ends, and reads 0 after edge M+1. The enable and read bits (bits 0 and 1 of 0x24) read 0 once the sequence ends. With the default windows, busy lasts 12 cycles (96 ns at 125 MHz).
- R7: A write to 0x24 while busy is ignored. The address and the data captured by the running sequence are unchanged.
- R8: Status bit 0 is cleared by writing 1 to 0x18. Writing 0 leaves it unchanged. When a capture and a clear fall on the same edge, the flag ends up set.
- R9: The read windows for chip select, program enable, load, address valid and strobe sit at 0x3C, 0x40, 0x44, 0x48 and 0x4C. Each register holds the start in bits 31:16 and the end in bits 15:0. Their reset values are:

  | Line | Start | End |
  |---|---|---|
  | chip select | 0 | 11 |
  | program enable | 0 | 11 |
  | load | 0 | 11 |
  | address valid | 2 | 10 |
  | strobe | 5 | 8 |

  The registers at 0x28 through 0x38 read back what was written to them and have no effect on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| fuse_cs_n | output | 1 | Macro chip select, active low |
| fuse_pgm_en | output | 1 | Macro program enable line |
| fuse_load | output | 1 | Macro load line |
| fuse_addr_en | output | 1 | Macro address-valid line |
| fuse_strobe | output | 1 | Macro sense strobe |
| fuse_addr | output | 10 | Word address to the macro |
| fuse_q | input | 32 | Macro data output |

## Verification
A wrong counter or window compare shows as a control pin that moves one or more cycles early or late, within the first dozen cycles after a command. The bench therefore compares every pin on every cycle of a sequence with the windows that were programmed.

A wrong capture point is caught at the end of the sequence. The captured word is then zero or belongs to the wrong address, because the bench's fuse model drives data only while load, address valid, strobe and chip select are all active.

Lost command gating, or a busy flag that stays set, shows in the data or busy readback on the next command.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int NLINE = 5;

  typedef enum logic [2:0] {
    L_CS = 3'd0,
    L_PG = 3'd1,
    L_LD = 3'd2,
    L_AV = 3'd3,
    L_ST = 3'd4
  } line_e;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_AUTO = 8'h24;
  localparam logic [7:0] OFS_PTIM = 8'h28;
  localparam logic [7:0] OFS_RTIM = 8'h3C;

  function automatic logic [31:0] rd_default(input int idx);
    logic [31:0] v;
    case (idx)
      3:       v = {16'd2, 16'd10};
      4:       v = {16'd5, 16'd8};
      default: v = {16'd0, 16'd11};
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fz_line.sv
module fz_line #(
  parameter int   CNT_W   = 16,
  parameter logic ACT_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] wstart,
  input  logic [CNT_W-1:0] wend,
  output logic             pin
);
  logic act;
  assign act = busy && (cnt >= wstart) && (cnt < wend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= ACT_LOW;
    else        pin <= act ^ ACT_LOW;
  end

  // R1/R4: outside a sequence every pin sits at its idle level
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pin == ACT_LOW));
endmodule

// File: rtl/fz_seq.sv
module fz_seq import fz_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NLINE-1:0][CNT_W-1:0] win_start,
  input  logic [NLINE-1:0][CNT_W-1:0] win_end,
  output logic                        busy,
  output logic [CNT_W-1:0]            cnt,
  output logic                        cap_pulse,
  output logic                        seq_end
);
  logic [CNT_W-1:0] max_end;

  always_comb begin
    max_end = '0;
    for (int i = 0; i < NLINE; i++)
      if (win_end[i] > max_end) max_end = win_end[i];
  end

  assign cap_pulse = busy && (cnt == win_end[L_ST]);
  assign seq_end   = busy && (cnt == max_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (seq_end) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= max_end));
  assert_end_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> !busy);
  assert_cap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
endmodule

// File: rtl/fz_regs.sv
module fz_regs import fz_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int FA_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [7:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic                        busy,
  input  logic                        seq_end,
  input  logic                        cap_pulse,
  input  logic [31:0]                 cap_data,
  output logic                        cmd_go,
  output logic                        user_mode,
  output logic [FA_W-1:0]             fuse_addr,
  output logic [NLINE-1:0][CNT_W-1:0] win_start,
  output logic [NLINE-1:0][CNT_W-1:0] win_end
);
  localparam int ADDR_LSB = 16;

  logic            user_q, done_q, en_q, rdreq_q;
  logic [FA_W-1:0] fa_q;
  logic [31:0]     data_q;
  logic [31:0]     rtim [NLINE];
  logic [31:0]     ptim [NLINE];

  logic wr_ctrl, wr_stat, wr_auto;
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_auto = bus_wr && (bus_addr == OFS_AUTO);

  assign cmd_go    = wr_auto && bus_wdata[0] && bus_wdata[1] && !user_q && !busy;
  assign user_mode = user_q;
  assign fuse_addr = fa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q  <= 1'b1;
      done_q  <= 1'b0;
      en_q    <= 1'b0;
      rdreq_q <= 1'b0;
      fa_q    <= '0;
      data_q  <= '0;
    end else begin
      if (wr_ctrl) user_q <= bus_wdata[0];
      if (cap_pulse) begin
        done_q <= 1'b1;
        data_q <= cap_data;
      end else if (wr_stat && bus_wdata[0]) begin
        done_q <= 1'b0;
      end
      if (cmd_go) begin
        en_q    <= 1'b1;
        rdreq_q <= 1'b1;
        fa_q    <= bus_wdata[ADDR_LSB +: FA_W];
      end else if (seq_end) begin
        en_q    <= 1'b0;
        rdreq_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINE; i++) begin
        rtim[i] <= rd_default(i);
        ptim[i] <= '0;
      end
    end else if (bus_wr) begin
      for (int i = 0; i < NLINE; i++) begin
        if (bus_addr == 8'(OFS_RTIM + 4*i)) rtim[i] <= bus_wdata;
        if (bus_addr == 8'(OFS_PTIM + 4*i)) ptim[i] <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NLINE; g++) begin : g_win
    assign win_start[g] = rtim[g][16 +: CNT_W];
    assign win_end[g]   = rtim[g][CNT_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata[0] = user_q;
        OFS_STAT: bus_rdata[0] = done_q;
        OFS_DATA: bus_rdata = data_q;
        OFS_AUTO: begin
          bus_rdata[31]               = busy;
          bus_rdata[ADDR_LSB +: FA_W] = fa_q;
          bus_rdata[1]                = rdreq_q;
          bus_rdata[0]                = en_q;
        end
        default: ;
      endcase
      for (int i = 0; i < NLINE; i++) begin
        if (bus_addr == 8'(OFS_RTIM + 4*i)) bus_rdata = rtim[i];
        if (bus_addr == 8'(OFS_PTIM + 4*i)) bus_rdata = ptim[i];
      end
    end
  end

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_auto) |=> $stable(fa_q));
  assert_done_on_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> (done_q && (data_q == $past(cap_data))));
  assert_seq_end_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && !cmd_go) |=> (!en_q && !rdreq_q));
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl import fz_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int FA_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            fuse_cs_n,
  output logic            fuse_pgm_en,
  output logic            fuse_load,
  output logic            fuse_addr_en,
  output logic            fuse_strobe,
  output logic [FA_W-1:0] fuse_addr,
  input  logic [31:0]     fuse_q
);
  logic                        cmd_go, user_mode, busy, cap_pulse, seq_end;
  logic [CNT_W-1:0]            cnt;
  logic [NLINE-1:0][CNT_W-1:0] win_start, win_end;
  logic [NLINE-1:0]            pins;

  fz_regs #(.CNT_W(CNT_W), .FA_W(FA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .seq_end(seq_end), .cap_pulse(cap_pulse), .cap_data(fuse_q),
    .cmd_go(cmd_go), .user_mode(user_mode), .fuse_addr(fuse_addr),
    .win_start(win_start), .win_end(win_end)
  );

  fz_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_go),
    .win_start(win_start), .win_end(win_end),
    .busy(busy), .cnt(cnt), .cap_pulse(cap_pulse), .seq_end(seq_end)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    fz_line #(.CNT_W(CNT_W), .ACT_LOW(g == int'(L_CS))) u_line (
      .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt),
      .wstart(win_start[g]), .wend(win_end[g]), .pin(pins[g])
    );
  end

  assign fuse_cs_n    = pins[L_CS];
  assign fuse_pgm_en  = pins[L_PG];
  assign fuse_load    = pins[L_LD];
  assign fuse_addr_en = pins[L_AV];
  assign fuse_strobe  = pins[L_ST];

  // R2: manual mode never lets a sequence begin
  assert_user_mode_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !busy) |=> !busy);
endmodule

// File: tb/sim_fuse_autoread_ctrl.sv
module sim_fuse_autoread_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fuse_cs_n, fuse_pgm_en, fuse_load, fuse_addr_en, fuse_strobe;
  logic [9:0]  fuse_addr;
  logic [31:0] fuse_q;

  always #4 clk = ~clk;

  fuse_autoread_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_cs_n(fuse_cs_n), .fuse_pgm_en(fuse_pgm_en), .fuse_load(fuse_load),
    .fuse_addr_en(fuse_addr_en), .fuse_strobe(fuse_strobe),
    .fuse_addr(fuse_addr), .fuse_q(fuse_q)
  );

  function automatic logic [31:0] fword(input logic [9:0] a);
    return 32'hC0DE_0000 ^ {a, a[5:0], ~a, a[5:0]};
  endfunction

  assign fuse_q = (fuse_strobe && fuse_load && fuse_addr_en && !fuse_cs_n)
                  ? fword(fuse_addr) : 32'h0;

  int checks = 0, errors = 0;
  int ws[5], we[5];
  logic [31:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // driver: issue a command and queue the word it should return
  task automatic issue_read(input logic [9:0] a);
    exp_q.push_back(fword(a));
    bwrite(8'h24, {6'd0, a, 14'd0, 2'b11});
  endtask

  // monitor side: pop and compare against the captured data register
  task automatic collect(input string req);
    logic [31:0] d;
    bread(8'h20, d);
    if (exp_q.size() == 0) chk({req, " queue empty"}, 32'h0, 32'h1);
    else chk(req, d, exp_q.pop_front());
  endtask

  // cycle-by-cycle pin walk after an accepting edge (R3 R4 R6)
  task automatic pin_walk(input logic [9:0] a);
    int mx;
    logic [31:0] d;
    logic [4:0] act;
    mx = 0;
    for (int i = 0; i < 5; i++) if (we[i] > mx) mx = we[i];
    for (int k = 1; k <= mx + 2; k++) begin
      @(negedge clk);
      act = {fuse_strobe, fuse_addr_en, fuse_load, fuse_pgm_en, ~fuse_cs_n};
      for (int i = 0; i < 5; i++)
        chk($sformatf("%s line%0d edge%0d", (i == 0) ? "R4" : "R3", i, k),
            {31'd0, act[i]}, {31'd0, ((k-1) >= ws[i]) && ((k-1) < we[i])});
      bread(8'h24, d);
      chk($sformatf("R6 busy edge%0d", k), {31'd0, d[31]}, {31'd0, k <= mx});
      if (k == 1) chk("R2 fuse_addr", {22'd0, fuse_addr}, {22'd0, a});
    end
    bread(8'h24, d);
    chk("R6 enable/read bits cleared", {30'd0, d[1:0]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n idle", {31'd0, fuse_cs_n}, 32'd1);
    chk("R1 other lines idle", {28'd0, fuse_pgm_en, fuse_load, fuse_addr_en, fuse_strobe}, 32'd0);
    bread(8'h18, d); chk("R1 status", d, 32'd0);
    bread(8'h20, d); chk("R1 data", d, 32'd0);
    bread(8'h00, d); chk("R1 ctrl manual", d, 32'd1);
    bread(8'h24, d); chk("R1 busy", d, 32'd0);

    // R9 defaults
    bread(8'h3C, d); chk("R9 cs default", d, {16'd0, 16'd11});
    bread(8'h48, d); chk("R9 addr-valid default", d, {16'd2, 16'd10});
    bread(8'h4C, d); chk("R9 strobe default", d, {16'd5, 16'd8});

    // R2 command in manual mode starts nothing
    bwrite(8'h24, {6'd0, 10'd3, 14'd0, 2'b11});
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      bread(8'h24, d);
      chk("R2 no busy in manual mode", {31'd0, d[31]}, 32'd0);
      chk("R2 cs_n stays high", {31'd0, fuse_cs_n}, 32'd1);
    end
    bread(8'h18, d); chk("R2 no completion in manual mode", d, 32'd0);

    bwrite(8'h00, 32'd0);
    bread(8'h00, d); chk("R2 ctrl auto", d, 32'd0);

    // R2 write with read bit missing is not a command
    bwrite(8'h24, {6'd0, 10'd3, 14'd0, 2'b01});
    @(negedge clk);
    bread(8'h24, d); chk("R2 enable-only not accepted", {31'd0, d[31]}, 32'd0);

    // default windows
    ws = '{0, 0, 0, 2, 5}; we = '{11, 11, 11, 10, 8};
    issue_read(10'd5);
    pin_walk(10'd5);
    collect("R5 data addr5");
    bread(8'h18, d); chk("R5 status set", d, 32'd1);

    // R8 write 0 keeps, write 1 clears
    bwrite(8'h18, 32'd0);
    bread(8'h18, d); chk("R8 write0 keeps", d, 32'd1);
    bwrite(8'h18, 32'd1);
    bread(8'h18, d); chk("R8 write1 clears", d, 32'd0);

    // R7 command during busy ignored
    issue_read(10'd7);
    bwrite(8'h24, {6'd0, 10'd9, 14'd0, 2'b11});
    bread(8'h24, d); chk("R7 address kept", {22'd0, d[25:16]}, 32'd7);
    repeat (14) @(negedge clk);
    collect("R7 data from first command");
    bread(8'h24, d); chk("R7 no second run", {31'd0, d[31]}, 32'd0);

    // R8 capture and clear on the same edge: set wins
    issue_read(10'd12);
    repeat (7) @(negedge clk);
    bwrite(8'h18, 32'd1);
    bread(8'h18, d); chk("R8 set wins over clear", d, 32'd1);
    repeat (6) @(negedge clk);
    collect("R5 data addr12");
    bwrite(8'h18, 32'd1);

    // R9 program windows are storage only
    bwrite(8'h28, 32'h1234_5678);
    bwrite(8'h38, 32'h0000_0001);
    bread(8'h28, d); chk("R9 prog cs readback", d, 32'h1234_5678);
    bread(8'h38, d); chk("R9 prog strobe readback", d, 32'h0000_0001);

    // R3 reprogrammed read windows, top address, empty pgm window
    bwrite(8'h3C, {16'd0, 16'd7});
    bwrite(8'h40, {16'd4, 16'd4});
    bwrite(8'h44, {16'd1, 16'd7});
    bwrite(8'h48, {16'd1, 16'd6});
    bwrite(8'h4C, {16'd3, 16'd4});
    bread(8'h4C, d); chk("R9 strobe readback", d, {16'd3, 16'd4});
    ws = '{0, 4, 1, 1, 3}; we = '{7, 4, 7, 6, 4};
    issue_read(10'h3FF);
    pin_walk(10'h3FF);
    collect("R5 data addr 3FF");
    bread(8'h18, d); chk("R5 status after short run", d, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule